// File: doc/BRIEF.md
# Two-Bank Maskable Interrupt Controller

This block gathers 64 already-synchronised interrupt lines into two banks of 32 and drives a single interrupt request to one CPU. Each source is either edge-sensitive, where a rising input is latched until software acknowledges it, or level-sensitive, where the pending bit simply mirrors the input. Each bank keeps its own trigger-mode pattern. After reset the lower bank is all edge-sensitive. In the upper bank, bits 20 to 28 are level-sensitive and the rest are edge-sensitive.

Software reaches the block through a 32-bit little-endian register bus inside a 4 KB window. A write takes effect on the single clock edge where its strobe is high. A read returns data on the clock edge that follows its strobe. Each bank occupies a 16-byte slot. The slot is chosen by subtracting 0x10 from the 12-bit offset and shifting right by four. Accesses whose slot index is 2 or more, including offsets below 0x10 that wrap to a large index, are ignored.

Top module: `twin_bank_irq_ctrl`

## Requirements
- R1: Line n belongs to bank n/32 at bit n%32. The bank index is ((addr - 0x10) mod 0x1000) >> 4, so bank 0 sits at 0x10-0x1F and bank 1 at 0x20-0x2F.
- R2: A write whose bank index is 2 or more changes no state. A read whose bank index is 2 or more returns 0.
- R3: Within a slot, word offset 0x0 reads the pending events, 0x4 reads and writes the enable mask, 0x8 is a write-1-to-clear acknowledge, and 0xC reads the sampled levels. An access with addr[1:0] nonzero is ignored and reads as 0.
- R4: An edge-mode source sets its pending bit when its input goes from 0 to 1. The bit stays set after the input falls, until it is acknowledged.
- R5: A level-mode pending bit equals the input level sampled at the previous edge. An acknowledge cannot clear it while the input is still high.
- R6: The levels register holds every line's value from the previous clock edge, whatever the source's mode.
- R7: cpu_irq_o is high exactly when (pending & mask) is nonzero in either bank. It changes on the clock edge that updates those registers.
- R8: If an acknowledge and a new rising edge hit the same bit on the same edge, the bit stays set.
- R9: Reset clears events, masks, levels, read data and the output. Afterwards bank 0 is all edge mode and bank 1 has mode pattern 0x1FF00000, so global lines 52-60 are level mode and lines 51 and 61 are edge mode.
- R10: Read data appears one clock edge after bus_rd_i and then holds. The acknowledge offset reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 64 | Synchronised interrupt levels, bank 1 in bits 63:32 |
| bus_addr_i | input | 12 | Byte offset within the 4 KB window |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |

## Verification
Two functions can meet on one edge: a software acknowledge of an edge-mode bit and a fresh rising edge on that same line. The bench provokes this by dropping a line for one cycle and then raising it again in the cycle where it writes 1 to that bit's acknowledge. Passing means cpu_irq_o stays high and the next events read still shows the bit. A similar collision, an acknowledge of a level-mode bit whose input stays high, is judged the same way: the bit survives and the request persists until the line falls.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned SLOT_SHIFT = 4;
  localparam int unsigned SLOT_BASE  = 16;

  typedef enum logic [1:0] {
    REG_EVT  = 2'd0,
    REG_MASK = 2'd1,
    REG_ACK  = 2'd2,
    REG_LVL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] bank_sel_o,
  output reg_sel_e             reg_o,
  output logic                 hit_o
);
  localparam int unsigned IDX_W = ADDR_W - SLOT_SHIFT;

  logic [ADDR_W-1:0] offs;
  logic [IDX_W-1:0]  idx;
  logic              aligned;

  // wraps modulo window size, so offsets below the base land on a huge index
  assign offs    = addr_i - ADDR_W'(SLOT_BASE);
  assign idx     = offs[ADDR_W-1:SLOT_SHIFT];
  assign aligned = (offs[1:0] == 2'b00);
  assign hit_o   = aligned && (idx < IDX_W'(NUM_BANKS));
  assign reg_o   = reg_sel_e'(offs[3:2]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    assign bank_sel_o[b] = aligned && (idx == IDX_W'(b));
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int unsigned          W        = 32,
  parameter logic [W-1:0]         LVL_MODE = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lines_i,
  input  logic         mask_we_i,
  input  logic         ack_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] evt_q, mask_q, lvl_q;
  logic [W-1:0] rise, ack, evt_d;
  logic         armed_q;

  assign rise = lines_i & ~lvl_q;
  assign ack  = ack_we_i ? wdata_i : '0;
  // edge sources: rising edge beats a same-cycle acknowledge
  assign evt_d = (LVL_MODE & lines_i) | (~LVL_MODE & ((evt_q & ~ack) | rise));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q   <= '0;
      mask_q  <= '0;
      lvl_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      evt_q   <= evt_d;
      lvl_q   <= lines_i;
      armed_q <= 1'b1;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign evt_o  = evt_q;
  assign mask_o = mask_q;
  assign lvl_o  = lvl_q;

  // R4 and R8: a rising edge on an edge source always leaves its bit set
  p_edge_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && ((rise & ~LVL_MODE) != '0)) |=>
      ((evt_q & $past(rise & ~LVL_MODE)) == $past(rise & ~LVL_MODE)));

  p_edge_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !ack_we_i) |=>
      ((evt_q & $past(evt_q & ~LVL_MODE)) == $past(evt_q & ~LVL_MODE)));

  p_level_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> ((evt_q & LVL_MODE) == ($past(lines_i) & LVL_MODE)));

  p_lvl_track_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> (lvl_q == $past(lines_i)));
endmodule

// File: rtl/twin_bank_irq_ctrl.sv
module twin_bank_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned  NUM_BANKS      = 2,
  parameter int unsigned  BANK_W         = 32,
  parameter int unsigned  ADDR_W         = 12,
  parameter logic [31:0]  UPPER_LVL_MODE = 32'h1FF0_0000
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_BANKS*BANK_W-1:0] irq_lines_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic                        bus_wr_i,
  input  logic [BANK_W-1:0]           bus_wdata_i,
  input  logic                        bus_rd_i,
  output logic [BANK_W-1:0]           bus_rdata_o,
  output logic                        cpu_irq_o
);
  logic [NUM_BANKS-1:0]             bank_sel;
  reg_sel_e                         reg_sel;
  logic                             hit;
  logic [NUM_BANKS-1:0][BANK_W-1:0] evt_all, mask_all, lvl_all;
  logic [NUM_BANKS-1:0]             pend;
  logic [BANK_W-1:0]                rd_word, rdata_q;

  irqc_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .addr_i     (bus_addr_i),
    .bank_sel_o (bank_sel),
    .reg_o      (reg_sel),
    .hit_o      (hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] MODE = (b == 1) ? BANK_W'(UPPER_LVL_MODE) : '0;
    irqc_bank #(.W(BANK_W), .LVL_MODE(MODE)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lines_i   (irq_lines_i[b*BANK_W +: BANK_W]),
      .mask_we_i (bus_wr_i && bank_sel[b] && (reg_sel == REG_MASK)),
      .ack_we_i  (bus_wr_i && bank_sel[b] && (reg_sel == REG_ACK)),
      .wdata_i   (bus_wdata_i),
      .evt_o     (evt_all[b]),
      .mask_o    (mask_all[b]),
      .lvl_o     (lvl_all[b])
    );
    assign pend[b] = |(evt_all[b] & mask_all[b]);
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel[b]) begin
        unique case (reg_sel)
          REG_EVT:  rd_word = evt_all[b];
          REG_MASK: rd_word = mask_all[b];
          REG_ACK:  rd_word = '0;
          REG_LVL:  rd_word = lvl_all[b];
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_word;
  end

  assign bus_rdata_o = rdata_q;
  assign cpu_irq_o   = |pend;

  p_sel_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_sel));

  p_far_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && !hit) |=> $stable(mask_all));

  p_far_rd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && !hit) |=> (bus_rdata_o == '0));

  p_no_mask_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_all == '0) |-> !cpu_irq_o);

  p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> $stable(bus_rdata_o));
endmodule

// File: tb/twin_bank_irq_ctrl_test.sv
`timescale 1ns/100ps
module twin_bank_irq_ctrl_test;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

  typedef struct packed {
    logic [63:0] lines;
    logic [1:0]  op;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        irq;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] L0  = 64'h1;
  localparam logic [63:0] L20 = 64'h10_0000;
  localparam logic [63:0] L32 = 64'h1_0000_0000;
  localparam logic [63:0] L52 = 64'h0010_0000_0000_0000;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{64'h0, OP_RD,   12'h010, 32'h0,        32'h0,        1'b0, 8'd9},  // R9 events clear
    '{L0,    OP_IDLE, 12'h000, 32'h0,        32'h0,        1'b0, 8'd7},  // R7 masked event quiet
    '{L0,    OP_WR,   12'h014, 32'h1,        32'h0,        1'b1, 8'd7},  // R7 unmask raises
    '{64'h0, OP_RD,   12'h010, 32'h0,        32'h1,        1'b1, 8'd4},  // R4 latched after fall
    '{64'h0, OP_WR,   12'h018, 32'h1,        32'h0,        1'b0, 8'd3},  // R3 ack clears
    '{64'h0, OP_RD,   12'h01C, 32'h0,        32'h0,        1'b0, 8'd6},  // R6 levels low
    '{L52,   OP_WR,   12'h024, 32'h0010_0000,32'h0,        1'b1, 8'd1},  // R1 bank1 mask
    '{L52,   OP_WR,   12'h028, 32'h0010_0000,32'h0,        1'b1, 8'd5},  // R5 ack on live level
    '{64'h0, OP_RD,   12'h020, 32'h0,        32'h0010_0000,1'b0, 8'd5},  // R5 follows level
    '{64'h0, OP_RD,   12'h020, 32'h0,        32'h0,        1'b0, 8'd5},  // R5 dropped
    '{L32,   OP_WR,   12'h024, 32'h1,        32'h0,        1'b1, 8'd4},  // R4 bank1 edge
    '{L32,   OP_WR,   12'h028, 32'h1,        32'h0,        1'b0, 8'd3},  // R3 ack bank1
    '{64'h0, OP_IDLE, 12'h000, 32'h0,        32'h0,        1'b0, 8'd4},
    '{L32,   OP_WR,   12'h028, 32'h1,        32'h0,        1'b1, 8'd8},  // R8 edge beats ack
    '{L32,   OP_RD,   12'h020, 32'h0,        32'h1,        1'b1, 8'd8},  // R8 bit kept
    '{L32,   OP_WR,   12'h034, 32'h0,        32'h0,        1'b1, 8'd2},  // R2 far mask write
    '{L32,   OP_WR,   12'h038, 32'hFFFF_FFFF,32'h0,        1'b1, 8'd2},  // R2 far ack write
    '{L32,   OP_RD,   12'h030, 32'h0,        32'h0,        1'b1, 8'd2},  // R2 far read zero
    '{L32,   OP_WR,   12'h004, 32'h0,        32'h0,        1'b1, 8'd1},  // R1 below base wraps
    '{L32,   OP_RD,   12'h014, 32'h0,        32'h1,        1'b1, 8'd1},  // R1 mask0 intact
    '{L32,   OP_RD,   12'h02C, 32'h0,        32'h1,        1'b1, 8'd6},  // R6 bank1 levels
    '{L32,   OP_RD,   12'h028, 32'h0,        32'h0,        1'b1, 8'd10}, // R10 ack reads 0
    '{L32,   OP_RD,   12'h024, 32'h0,        32'h1,        1'b1, 8'd3},  // R3 mask readback
    '{L32|L20,OP_WR,  12'h014, 32'h0010_0000,32'h0,        1'b1, 8'd1},  // R1 bank0 bit20 edge
    '{L32,   OP_RD,   12'h010, 32'h0,        32'h0010_0000,1'b1, 8'd9},  // R9 bank0 is edge
    '{L32,   OP_RD,   12'h011, 32'h0,        32'h0,        1'b1, 8'd3}   // R3 unaligned reads 0
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] lines = '0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          total = 0, bad = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  twin_bank_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_lines_i(lines), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rd_i(rd),
    .bus_rdata_o(rdata), .cpu_irq_o(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int r,
                       input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%08h expected=%08h", r, what, act, exp);
    end
  endtask

  // drives at a falling edge, checks at the next falling edge
  task automatic step(input logic [63:0] ln, input logic [1:0] op, input logic [11:0] a,
                      input logic [31:0] d, input logic [31:0] ex, input logic ei,
                      input int r);
    lines = ln; addr = a; wdata = d;
    wr = (op == OP_WR); rd = (op == OP_RD);
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    if (op == OP_RD) check(rdata, ex, r, "rdata");
    check({31'b0, irq}, {31'b0, ei}, r, "irq");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R0 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({31'b0, irq}, 32'h0, 9, "irq in reset");      // R9
    check(rdata, 32'h0, 9, "rdata in reset");            // R9
    rst_ni = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++)
      step(VECS[i].lines, VECS[i].op, VECS[i].addr, VECS[i].data,
           VECS[i].exp, VECS[i].irq, int'(VECS[i].req));

    // R9: mid-run reset wipes pending and masks
    lines = '0;
    rst_ni = 1'b0;
    #1;
    check({31'b0, irq}, 32'h0, 9, "irq after reset");
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    step(64'h0, OP_RD, 12'h024, 32'h0, 32'h0, 1'b0, 9);  // R9 mask1 cleared
    step(64'h0, OP_RD, 12'h014, 32'h0, 32'h0, 1'b0, 9);
    step(64'h0, OP_RD, 12'h020, 32'h0, 32'h0, 1'b0, 9);
    // R9 mode boundaries: line 51 and 61 edge, 52 and 60 level
    step((64'h1 << 61) | (64'h1 << 60) | (64'h1 << 51) | L52, OP_IDLE, 12'h0,
         32'h0, 32'h0, 1'b0, 9);
    step(64'h0, OP_IDLE, 12'h0, 32'h0, 32'h0, 1'b0, 9);
    step(64'h0, OP_RD, 12'h020, 32'h0, 32'h2008_0000, 1'b0, 9);
    step(64'h0, OP_RD, 12'h02C, 32'h0, 32'h0, 1'b0, 6);   // R6 levels back low
    // R10: data holds without a read strobe
    step(64'h0, OP_IDLE, 12'h0, 32'h0, 32'h0, 1'b0, 10);
    check(rdata, 32'h0, 10, "rdata hold");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule